// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block runs one short, arbitrary transaction to a serial flash over a single data line. Software fills a bank of byte-wide transmit registers and writes the transaction length as a number of bits. It then sets the go bit in the control register. The engine drives chip select low and clocks the bits out MSB first, starting with the highest-indexed transmit byte. At the same time it shifts the flash's reply into a receive bank, and it drops the go bit when the transaction ends. A transaction holds at most six bytes in total, covering opcode, address, dummy and data.

The register port is a plain single-cycle write strobe with a combinational read. It has no back-pressure, and an access always completes in the cycle it is presented. SCLK is derived from the system clock: each SCLK half period lasts `HALF_DIV` system cycles. The bus runs in SPI mode 0.

Register map, by `reg_addr`:
- 0: control. Bit 2 is the go/busy bit.
- 1: bit count.
- 2 to 7: transmit bytes 0 to 5.
- 8 to 13: receive bytes 0 to 5.

Top module: `flash_cmd_shifter`

## Requirements
- R1: After reset, chip select is high (`spi_cs_n`=1), SCLK and MOSI are low, and every register reads 0.
- R2: Writing 1 to bit 2 of address 0 while idle, with a nonzero bit count, starts a transaction. Bit 2 of address 0 reads 1 for the whole transaction and clears by itself at the end.
- R3: Address 1 holds the transaction length in bits and reads back what was written. Any value above 48 (`NUM_BYTES`*8) is stored as 48.
- R4: MOSI carries exactly the counted number of bits. They are sent MSB first, starting from transmit byte 5 (address 7) and continuing down through the lower indices to byte 0 (address 2).
- R5: SCLK idles low. Each half period lasts `HALF_DIV` cycles, and the first rising edge comes `HALF_DIV` cycles after chip select falls. MOSI changes only on a falling SCLK edge or when chip select moves.
- R6: MISO is sampled on each rising SCLK edge. After an N-byte transaction, the byte received first reads from receive index N-1 (address 8+N-1), and the byte received last reads from index 0 (address 8).
- R7: Chip select stays low for one full SCLK period (2*`HALF_DIV` cycles) after the last falling edge. It rises on the same clock as the busy bit clears.
- R8: A go request with a bit count of 0 finishes at once. Chip select never falls, and bit 2 of address 0 reads 0 on the next cycle.
- R9: While busy, writes to the transmit bytes, the bit count and the control register have no effect. A second go request does not restart or lengthen the transaction.
- R10: The receive bytes are read-only, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The assertions check the bus rules on every cycle:
- SCLK stays low while the flash is deselected.
- MOSI moves only on a falling SCLK edge or when chip select moves.
- Chip select falls only together with busy and rises exactly as busy clears.
- The bit count stays frozen for as long as busy holds.

Only the scenarios can show the rest: the byte order on MOSI, the reversed placement of the reply in the receive bank, the clamp on the bit count, and the immediate completion of a zero-length request. These depend on the data chosen and on register readback after the transaction.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} fcs_state_e;

  localparam int unsigned CTRL_ADDR   = 0;
  localparam int unsigned BITCNT_ADDR = 1;
  localparam int unsigned TX_BASE     = 2;
  localparam int unsigned GO_BIT      = 2;
endpackage

// File: rtl/fcs_regs.sv
module fcs_regs
  import fcs_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int ADDR_W    = 4,
  parameter int CNT_W     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [7:0]             rdata,
  input  logic [NUM_BYTES*8-1:0] rx_bits,
  input  logic                   done,
  output logic                   start,
  output logic                   busy,
  output logic [CNT_W-1:0]       bit_count,
  output logic [NUM_BYTES*8-1:0] tx_bits
);
  localparam int MAX_BITS = NUM_BYTES * 8;
  localparam int RX_BASE  = TX_BASE + NUM_BYTES;

  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [MAX_BITS-1:0]  tx_q;
  logic                 wr_ok;
  logic                 go_req;

  // register writes are accepted only while the engine is idle
  assign wr_ok  = wr && !busy_q;
  assign go_req = wr_ok && (addr == ADDR_W'(CTRL_ADDR)) && wdata[GO_BIT];
  assign start  = go_req && (cnt_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      tx_q   <= '0;
    end else begin
      if (start) begin
        busy_q <= 1'b1;
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (wr_ok && (addr == ADDR_W'(BITCNT_ADDR))) begin
        if (int'(wdata) > MAX_BITS) cnt_q <= CNT_W'(MAX_BITS);
        else                        cnt_q <= CNT_W'(wdata);
      end
      for (int i = 0; i < NUM_BYTES; i++) begin
        if (wr_ok && (addr == ADDR_W'(TX_BASE + i))) tx_q[8*i +: 8] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(CTRL_ADDR))   rdata[GO_BIT] = busy_q;
    if (addr == ADDR_W'(BITCNT_ADDR)) rdata = 8'(cnt_q);
    for (int i = 0; i < NUM_BYTES; i++) begin
      if (addr == ADDR_W'(TX_BASE + i)) rdata = tx_q[8*i +: 8];
      if (addr == ADDR_W'(RX_BASE + i)) rdata = rx_bits[8*i +: 8];
    end
  end

  assign busy      = busy_q;
  assign bit_count = cnt_q;
  assign tx_bits   = tx_q;
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
  end

  assign expire = (cnt_q == '0);
endmodule

// File: rtl/fcs_engine.sv
module fcs_engine
  import fcs_pkg::*;
#(
  parameter int NUM_BYTES = 6,
  parameter int HALF_DIV  = 2,
  parameter int CNT_W     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [CNT_W-1:0]       bit_count,
  input  logic [NUM_BYTES*8-1:0] tx_bits,
  input  logic                   miso,
  output logic                   cs_n,
  output logic                   sclk,
  output logic                   mosi,
  output logic [NUM_BYTES*8-1:0] rx_bits,
  output logic                   done
);
  localparam int W  = NUM_BYTES * 8;
  localparam int TW = $clog2(2 * HALF_DIV + 1);

  fcs_state_e       state_q;
  logic             cs_n_q;
  logic             sclk_q;
  logic [W-1:0]     txsr_q;
  logic [W-1:0]     rxsr_q;
  logic [CNT_W-1:0] left_q;
  logic             expire;
  logic             tick;
  logic             last_fall;
  logic             t_load;
  logic [TW-1:0]    t_val;

  assign tick      = (state_q != ST_IDLE) && expire;
  assign last_fall = (state_q == ST_SHIFT) && sclk_q && (left_q == CNT_W'(1));
  assign t_load    = ((state_q == ST_IDLE) && start) || tick;
  assign t_val     = last_fall ? TW'(2 * HALF_DIV - 1) : TW'(HALF_DIV - 1);
  assign done      = (state_q == ST_TAIL) && expire;

  fcs_timer #(.CW(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expire   (expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cs_n_q  <= 1'b1;
      sclk_q  <= 1'b0;
      txsr_q  <= '0;
      rxsr_q  <= '0;
      left_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_SHIFT;
            cs_n_q  <= 1'b0;
            txsr_q  <= tx_bits;
            left_q  <= bit_count;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rxsr_q <= {rxsr_q[W-2:0], miso};
            end else begin
              sclk_q <= 1'b0;
              txsr_q <= {txsr_q[W-2:0], 1'b0};
              left_q <= left_q - CNT_W'(1);
              if (left_q == CNT_W'(1)) state_q <= ST_TAIL;
            end
          end
        end
        ST_TAIL: begin
          if (tick) begin
            cs_n_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n    = cs_n_q;
  assign sclk    = sclk_q;
  assign mosi    = !cs_n_q && txsr_q[W-1];
  assign rx_bits = rxsr_q;
endmodule

// File: rtl/flash_cmd_shifter.sv
module flash_cmd_shifter #(
  parameter int NUM_BYTES = 6,
  parameter int HALF_DIV  = 2,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int W     = NUM_BYTES * 8;
  localparam int CNT_W = $clog2(W + 1);

  logic             start;
  logic             busy;
  logic             done;
  logic [CNT_W-1:0] bit_count;
  logic [W-1:0]     tx_bits;
  logic [W-1:0]     rx_bits;

  fcs_regs #(
    .NUM_BYTES (NUM_BYTES),
    .ADDR_W    (ADDR_W),
    .CNT_W     (CNT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (reg_wr),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .rx_bits   (rx_bits),
    .done      (done),
    .start     (start),
    .busy      (busy),
    .bit_count (bit_count),
    .tx_bits   (tx_bits)
  );

  fcs_engine #(
    .NUM_BYTES (NUM_BYTES),
    .HALF_DIV  (HALF_DIV),
    .CNT_W     (CNT_W)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bit_count (bit_count),
    .tx_bits   (tx_bits),
    .miso      (spi_miso),
    .cs_n      (spi_cs_n),
    .sclk      (spi_sclk),
    .mosi      (spi_mosi),
    .rx_bits   (rx_bits),
    .done      (done)
  );
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             mosi,
  input logic             busy,
  input logic [CNT_W-1:0] bit_count
);
  AST_CS_ONLY_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n); // R8

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R5

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!$fell(sclk) && $stable(cs_n)) |-> $stable(mosi)); // R5

  AST_SELECT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> busy); // R2

  AST_RELEASE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> !busy); // R7

  AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(bit_count)); // R9
endmodule

bind flash_cmd_shifter fcs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (spi_cs_n),
  .sclk      (spi_sclk),
  .mosi      (spi_mosi),
  .busy      (busy),
  .bit_count (bit_count)
);

// File: tb/flash_cmd_shifter_test.sv
module flash_cmd_shifter_test;
  localparam int NB = 6;
  localparam int H  = 2;
  localparam int W  = NB * 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       miso = 1'b0;
  wire  [7:0] reg_rdata;
  wire        cs_n, sclk, mosi;

  always #10 clk = ~clk;

  flash_cmd_shifter #(.NUM_BYTES(NB), .HALF_DIV(H), .ADDR_W(4)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(cs_n),
    .spi_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // behavioural reference model, advanced on every rising clock edge
  bit           m_active = 0;
  int           e = 0, m_bits = 0, m_end = 0, m_cnt = 0;
  logic [7:0]   m_tx [NB];
  logic [W-1:0] m_stream = '0;
  bit           rx_pat[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_active = 0; e = 0; m_cnt = 0;
      for (int i = 0; i < NB; i++) m_tx[i] = '0;
    end else if (m_active) begin
      if (e + 1 >= m_end) m_active = 0;
      else e = e + 1;
    end else if (reg_wr) begin
      if (reg_addr == 0 && reg_wdata[2] && m_cnt != 0) begin
        m_active = 1; e = 0; m_bits = m_cnt;
        m_end = 2 * m_bits * H + 2 * H;
        for (int i = 0; i < NB; i++) m_stream[8*i +: 8] = m_tx[i];
      end else if (reg_addr == 1) begin
        m_cnt = (int'(reg_wdata) > W) ? W : int'(reg_wdata);
      end else if (reg_addr >= 2 && reg_addr < 2 + NB) begin
        m_tx[int'(reg_addr) - 2] = reg_wdata;
      end
    end
  end

  // compare every cycle at the falling edge, then drive MISO for the next edge
  always @(negedge clk) begin
    if (rst_n) begin
      int   b;
      logic xs, xm;
      b  = m_active ? e / (2 * H) : 0;
      xs = m_active && (e < 2 * m_bits * H) && (((e / H) % 2) == 1);
      xm = (m_active && b < W) ? m_stream[W-1-b] : 1'b0;
      chk(cs_n == !m_active, "R7 chip select", cs_n, !m_active);
      chk(sclk == xs, "R5 sclk", sclk, xs);
      chk(mosi == xm, "R4 mosi", mosi, xm);
      if (!reg_wr && reg_addr == 0) chk(reg_rdata[2] == m_active, "R2 busy bit", reg_rdata[2], m_active);
      miso = (m_active && b < rx_pat.size()) ? rx_pat[b] : 1'b0;
    end
  end

  task automatic wr(input int a, input int d);
    @(posedge clk); #2;
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(posedge clk); #2;
    reg_wr = 1'b0; reg_addr = '0;
  endtask

  task automatic rd(input int a, output int d);
    @(posedge clk); #2;
    reg_addr = 4'(a);
    @(negedge clk);
    d = int'(reg_rdata);
    @(posedge clk); #2;
    reg_addr = '0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_active);
    repeat (2) @(negedge clk);
  endtask

  task automatic load_tx(input logic [W-1:0] v);
    for (int i = 0; i < NB; i++) wr(2 + i, int'(v[8*i +: 8]));
  endtask

  task automatic set_rx(input logic [W-1:0] pat, input int n);
    rx_pat.delete();
    for (int m = 0; m < n; m++) rx_pat.push_back(pat[W-1-m]);
  endtask

  task automatic check_rx(input logic [W-1:0] pat, input int n);
    int d;
    for (int i = 0; i < n / 8; i++) begin
      rd(8 + i, d);
      chk(d == int'(pat[W-n+8*i +: 8]), "R6 receive byte", d, int'(pat[W-n+8*i +: 8]));
    end
  endtask

  initial begin
    int d;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk reset", sclk, 0);
    chk(mosi == 1'b0, "R1 mosi reset", mosi, 0);
    for (int a = 0; a < 14; a++) begin
      rd(a, d);
      chk(d == 0, "R1 register reset", d, 0);
    end

    // R3 clamp and readback
    wr(1, 200); rd(1, d); chk(d == 48, "R3 clamp", d, 48);
    wr(1, 16);  rd(1, d); chk(d == 16, "R3 readback", d, 16);

    // R10 read-only receive bank, unmapped address
    wr(8, 8'hAA); rd(8, d); chk(d == 0, "R10 receive read-only", d, 0);
    rd(15, d); chk(d == 0, "R10 unmapped", d, 0);

    // full six-byte transaction
    load_tx(48'h9F_03_12_34_56_78);
    set_rx(48'hC3_5A_0F_F0_81_7E, 48);
    wr(1, 48); wr(0, 4);
    rd(0, d); chk(d == 4, "R2 busy during transfer", d, 4);
    wait_idle();
    rd(0, d); chk(d == 0, "R2 self clear", d, 0);
    check_rx(48'hC3_5A_0F_F0_81_7E, 48);

    // two-byte transaction
    load_tx(48'h05_AB_00_00_00_00);
    set_rx(48'hA5_3C_00_00_00_00, 16);
    wr(1, 16); wr(0, 4);
    wait_idle();
    check_rx(48'hA5_3C_00_00_00_00, 16);

    // non-byte length, checked by the per-cycle model
    wr(1, 3); wr(0, 4);
    wait_idle();

    // R8 zero length
    wr(1, 0); wr(0, 4);
    rd(0, d); chk(d == 0, "R8 zero length busy", d, 0);
    chk(cs_n == 1'b1, "R8 zero length cs_n", cs_n, 1);

    // R9 writes while busy
    load_tx(48'h0B_01_02_03_44_55);
    set_rx(48'h12_34_56_78_00_00, 32);
    wr(1, 32); wr(0, 4);
    wr(7, 8'hFF); wr(1, 8); wr(0, 4); wr(2, 8'h11);
    wait_idle();
    rd(7, d); chk(d == 8'h0B, "R9 tx byte kept", d, 8'h0B);
    rd(2, d); chk(d == 8'h55, "R9 tx byte kept", d, 8'h55);
    rd(1, d); chk(d == 32, "R9 count kept", d, 32);
    check_rx(48'h12_34_56_78_00_00, 32);

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule